// File: doc/BRIEF.md
# Scatter Descriptor Segmenter

The segmenter turns one message, given as a sequence of scatter entries (address, byte length, last-entry marker), into a chain of ring descriptors. An entry longer than the per-descriptor cap is cut into full-size pieces that each advance the address by the cap, followed by one piece holding the remainder. Every descriptor leaves the block as a write strobe with its ring index, address, length and four position flags: first-of-message, end-of-message, interrupt-when-done and wrap-marker.

The caller opens a message with a header that carries the number of descriptors the message will take. The block compares that number with the free space between its own write index and the consumer index supplied from outside. If the message fits, the block takes the entries one at a time. Otherwise it refuses the header, writes nothing, raises a one-cycle refusal pulse and bumps a saturating refusal counter. When the last descriptor is written, a total strobe reports the message's first ring index and its descriptor count, so the consumer can reclaim the whole chain in one step.

Top module: `dseg_segmenter`

## Requirements
- R1: An entry of length L yields pieces of length min(remaining, 2^MAX_W), and each piece's address is 2^MAX_W above the previous one. An exact multiple of the cap ends with a full-size piece and never with a zero-length one. A zero-length entry yields exactly one descriptor of length 0.
- R2: The first-of-message flag is set on the first descriptor of an accepted message and on no other descriptor.
- R3: The end-of-message and interrupt-when-done flags are set together, only on the final piece of the entry marked last. The total strobe fires in the same cycle.
- R4: The wrap-marker flag is set exactly on descriptors written at ring index 2^IDX_W − 1.
- R5: Each descriptor is written at the current write index, which then advances by one modulo 2^IDX_W. The index carries on across messages and starts at 0.
- R6: Free space is (2^IDX_W − 1) − ((write index − consumer index) mod 2^IDX_W). A header whose need exceeds it is refused: no descriptor is written and the write index does not move.
- R7: The total strobe carries the ring index of the message's first descriptor and the number of descriptors written for it.
- R8: A refused header raises the refusal pulse in the cycle after the header handshake, and the refusal counter rises by one in the same edge. The counter holds at its all-ones value.
- R9: After synchronous reset, all strobes, flags, the write index and the refusal counter are 0, and the header ready is 1.
- R10: The header ready is high only while no message is open. The entry ready is high only while a message is open and no earlier entry is still being cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cons_idx | input | IDX_W | Consumer (reclaim) ring index |
| hdr_valid | input | 1 | Message header offered |
| hdr_need | input | NEED_W | Descriptors the message will take |
| hdr_ready | output | 1 | Header can be taken (no message open) |
| ent_valid | input | 1 | Scatter entry offered |
| ent_addr | input | ADDR_W | Entry start address |
| ent_len | input | LEN_W | Entry length in bytes |
| ent_last | input | 1 | Entry is the message's last |
| ent_ready | output | 1 | Entry can be taken |
| dsc_we | output | 1 | Descriptor write strobe |
| dsc_idx | output | IDX_W | Ring index of the descriptor |
| dsc_addr | output | ADDR_W | Descriptor buffer address |
| dsc_len | output | MAX_W+1 | Descriptor buffer length |
| dsc_sof | output | 1 | First descriptor of the message |
| dsc_eof | output | 1 | Last descriptor of the message |
| dsc_ioc | output | 1 | Interrupt when this descriptor completes |
| dsc_eot | output | 1 | Descriptor sits at the last ring slot |
| tot_we | output | 1 | Message total strobe |
| tot_idx | output | IDX_W | Ring index of the message's first descriptor |
| tot_cnt | output | IDX_W+1 | Descriptors written for the message |
| wr_idx | output | IDX_W | Current write index |
| nospc | output | 1 | One-cycle refusal pulse |
| nospc_cnt | output | REJ_W | Saturating refusal count |

## Verification
The bench sweeps entry lengths around the cap: zero, one, just below, equal to, just above and exact multiples of the cap. A splitter that rounds wrongly would emit an extra zero-length piece or drop the remainder. Walking the write index around the small ring checks that the wrap marker lands only on the last slot and that the index wraps instead of sticking. The bench runs every occupancy against every need from one to one past the ring, so an off-by-one in the space formula shows up as a wrongly accepted message with stray writes, or a wrongly refused one. Enough refusals are forced to show whether the counter wraps past its top value.

// File: rtl/dseg_pkg.sv
// Shared types for the descriptor segmenter.
// Assumes nothing beyond SystemVerilog 2017.
package dseg_pkg;

    // Message-level state of the segmenter.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } dseg_state_e;

    // Position flags carried by each descriptor.
    typedef struct packed {
        logic sof;
        logic eof;
        logic ioc;
        logic eot;
    } dseg_flags_t;

endpackage

// File: rtl/dseg_space.sv
// Ring space check: works out the free slots between the write and
// consumer indices and decides whether a message of a given need fits.
// Assumes NEED_W >= IDX_W and one slot always kept empty.
module dseg_space #(
    parameter int IDX_W  = 9,
    parameter int NEED_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  cons_idx,
    input  logic [NEED_W-1:0] need,
    output logic [IDX_W-1:0]  avail,
    output logic              fits
);
    localparam logic [IDX_W-1:0] USABLE = '1;

    logic [IDX_W-1:0] used;

    // Occupancy wraps naturally in IDX_W bits; free space excludes the guard slot.
    always_comb begin
        used  = wr_idx - cons_idx;
        avail = USABLE - used;
        fits  = (NEED_W'(avail) >= need);
    end
endmodule

// File: rtl/dseg_chunker.sv
// Entry splitter: holds one scatter entry and hands out one piece per
// cycle, each at most 2^MAX_W bytes, advancing the address by the cap.
// Assumes LEN_W > MAX_W and ADDR_W > MAX_W; load only while not busy.
module dseg_chunker #(
    parameter int ADDR_W = 40,
    parameter int LEN_W  = 24,
    parameter int MAX_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              ld_last,
    output logic              busy,
    output logic [ADDR_W-1:0] pc_addr,
    output logic [MAX_W:0]    pc_len,
    output logic              pc_final,
    output logic              pc_last
);
    localparam logic [LEN_W-1:0]  CAP_LEN  = LEN_W'(1) << MAX_W;
    localparam logic [ADDR_W-1:0] CAP_STEP = ADDR_W'(1) << MAX_W;
    localparam logic [MAX_W:0]    CAP_PC   = (MAX_W+1)'(1) << MAX_W;

    logic              busy_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              last_q;

    // Current piece: the remainder if it fits under the cap, else a full cap.
    always_comb begin
        busy     = busy_q;
        pc_addr  = addr_q;
        pc_final = (rem_q <= CAP_LEN);
        pc_len   = pc_final ? rem_q[MAX_W:0] : CAP_PC;
        pc_last  = last_q;
    end

    // Load a new entry or step to the next piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            busy_q <= 1'b1;
            addr_q <= ld_addr;
            rem_q  <= ld_len;
            last_q <= ld_last;
        end else if (busy_q) begin
            if (pc_final) begin
                busy_q <= 1'b0;
            end else begin
                addr_q <= addr_q + CAP_STEP;
                rem_q  <= rem_q - CAP_LEN;
            end
        end
    end
endmodule

// File: rtl/dseg_satcnt.sv
// Saturating event counter: counts up by one per event and holds at all-ones.
// Assumes one event per cycle at most.
module dseg_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    assign cnt = cnt_q;

    // Count events until the top value is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/dseg_segmenter.sv
// Descriptor segmenter top. It admits a message only when the ring has room
// for the declared need, cuts each scatter entry into capped pieces, writes
// one flagged descriptor per cycle and reports the message total at the end.
// Assumes the declared need matches the pieces the entries produce and that
// entries are offered only while ent_ready is high.
module dseg_segmenter
    import dseg_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int ADDR_W = 40,
    parameter int LEN_W  = 24,
    parameter int MAX_W  = 14,
    parameter int NEED_W = IDX_W + 1,
    parameter int REJ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cons_idx,
    input  logic              hdr_valid,
    input  logic [NEED_W-1:0] hdr_need,
    output logic              hdr_ready,
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [LEN_W-1:0]  ent_len,
    input  logic              ent_last,
    output logic              ent_ready,
    output logic              dsc_we,
    output logic [IDX_W-1:0]  dsc_idx,
    output logic [ADDR_W-1:0] dsc_addr,
    output logic [MAX_W:0]    dsc_len,
    output logic              dsc_sof,
    output logic              dsc_eof,
    output logic              dsc_ioc,
    output logic              dsc_eot,
    output logic              tot_we,
    output logic [IDX_W-1:0]  tot_idx,
    output logic [IDX_W:0]    tot_cnt,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              nospc,
    output logic [REJ_W-1:0]  nospc_cnt
);
    localparam logic [IDX_W-1:0] LAST_SLOT = '1;

    dseg_state_e       state_q;
    logic [IDX_W-1:0]  wr_q;
    logic [IDX_W-1:0]  start_q;
    logic [IDX_W:0]    cnt_q;
    logic              first_q;

    logic [IDX_W-1:0]  avail;
    logic              fits;
    logic              hdr_fire, accept, reject, ent_fire;
    logic              emit, done;
    logic              ck_busy, ck_final, ck_last;
    logic [ADDR_W-1:0] ck_addr;
    logic [MAX_W:0]    ck_len;
    dseg_flags_t       flg;

    dseg_space #(
        .IDX_W  (IDX_W),
        .NEED_W (NEED_W)
    ) u_space (
        .wr_idx   (wr_q),
        .cons_idx (cons_idx),
        .need     (hdr_need),
        .avail    (avail),
        .fits     (fits)
    );

    dseg_chunker #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .MAX_W  (MAX_W)
    ) u_chunk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ent_fire),
        .ld_addr  (ent_addr),
        .ld_len   (ent_len),
        .ld_last  (ent_last),
        .busy     (ck_busy),
        .pc_addr  (ck_addr),
        .pc_len   (ck_len),
        .pc_final (ck_final),
        .pc_last  (ck_last)
    );

    dseg_satcnt #(
        .W (REJ_W)
    ) u_rej (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (reject),
        .cnt   (nospc_cnt)
    );

    // Handshakes and per-cycle events.
    always_comb begin
        hdr_ready = (state_q == ST_IDLE);
        hdr_fire  = hdr_valid && hdr_ready;
        accept    = hdr_fire && fits;
        reject    = hdr_fire && !fits;
        ent_ready = (state_q == ST_FILL) && !ck_busy;
        ent_fire  = ent_valid && ent_ready;
        emit      = ck_busy;
        done      = ck_busy && ck_final && ck_last;
        flg.sof   = first_q;
        flg.eof   = done;
        flg.ioc   = done;
        flg.eot   = (wr_q == LAST_SLOT);
        wr_idx    = wr_q;
    end

    // Message state: open on an admitted header, close on the final piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (accept) begin
            state_q <= ST_FILL;
        end else if (done) begin
            state_q <= ST_IDLE;
        end
    end

    // Ring write index, message start, first marker and descriptor count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else begin
            if (accept) begin
                start_q <= wr_q;
                cnt_q   <= '0;
                first_q <= 1'b1;
            end else if (emit) begin
                wr_q    <= wr_q + IDX_W'(1);
                cnt_q   <= cnt_q + (IDX_W+1)'(1);
                first_q <= 1'b0;
            end
        end
    end

    // Registered descriptor, total and refusal outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsc_we   <= 1'b0;
            dsc_idx  <= '0;
            dsc_addr <= '0;
            dsc_len  <= '0;
            dsc_sof  <= 1'b0;
            dsc_eof  <= 1'b0;
            dsc_ioc  <= 1'b0;
            dsc_eot  <= 1'b0;
            tot_we   <= 1'b0;
            tot_idx  <= '0;
            tot_cnt  <= '0;
            nospc    <= 1'b0;
        end else begin
            dsc_we <= emit;
            tot_we <= done;
            nospc  <= reject;
            if (emit) begin
                dsc_idx  <= wr_q;
                dsc_addr <= ck_addr;
                dsc_len  <= ck_len;
                dsc_sof  <= flg.sof;
                dsc_eof  <= flg.eof;
                dsc_ioc  <= flg.ioc;
                dsc_eot  <= flg.eot;
            end
            if (done) begin
                tot_idx <= start_q;
                tot_cnt <= cnt_q + (IDX_W+1)'(1);
            end
        end
    end
endmodule

// File: rtl/dseg_segmenter_chk.sv
// Property checker for the segmenter, attached by bind. It watches only
// the top-level ports and keeps a little history of its own.
module dseg_segmenter_chk #(
    parameter int IDX_W = 9,
    parameter int MAX_W = 14,
    parameter int REJ_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dsc_we,
    input logic [IDX_W-1:0] dsc_idx,
    input logic [MAX_W:0]   dsc_len,
    input logic             dsc_sof,
    input logic             dsc_eof,
    input logic             dsc_ioc,
    input logic             dsc_eot,
    input logic             tot_we,
    input logic [IDX_W-1:0] tot_idx,
    input logic [IDX_W-1:0] wr_idx,
    input logic             nospc,
    input logic [REJ_W-1:0] nospc_cnt
);
    localparam logic [IDX_W-1:0] LAST_SLOT = '1;
    localparam logic [MAX_W:0]   CAP       = (MAX_W+1)'(1) << MAX_W;
    localparam logic [REJ_W-1:0] REJ_TOP   = '1;

    logic             seen_q;
    logic [IDX_W-1:0] prev_idx_q;
    logic             open_q;
    logic [IDX_W-1:0] sof_idx_q;

    // History of the last descriptor and the open message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            prev_idx_q <= '0;
            open_q     <= 1'b0;
            sof_idx_q  <= '0;
        end else if (dsc_we) begin
            seen_q     <= 1'b1;
            prev_idx_q <= dsc_idx;
            if (dsc_sof) sof_idx_q <= dsc_idx;
            open_q     <= !dsc_eof;
        end
    end

    p_len_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_we |-> (dsc_len <= CAP));

    p_sof_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_we |-> (dsc_sof == !open_q));

    p_eof_tot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_we && dsc_eof) |-> (dsc_ioc && tot_we));

    p_tot_eof_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tot_we |-> (dsc_we && dsc_eof));

    p_eot_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_we && dsc_eot) |-> (dsc_idx == LAST_SLOT));

    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_we && seen_q) |-> (dsc_idx == prev_idx_q + IDX_W'(1)));

    p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nospc |-> (!dsc_we && $stable(wr_idx)));

    p_tot_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tot_we |-> (tot_idx == (dsc_sof ? dsc_idx : sof_idx_q)));

    p_rej_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nospc && ($past(nospc_cnt) != REJ_TOP)) |-> (nospc_cnt == $past(nospc_cnt) + REJ_W'(1)));

    p_rej_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !nospc |-> $stable(nospc_cnt));
endmodule

bind dseg_segmenter dseg_segmenter_chk #(
    .IDX_W (IDX_W),
    .MAX_W (MAX_W),
    .REJ_W (REJ_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dsc_we    (dsc_we),
    .dsc_idx   (dsc_idx),
    .dsc_len   (dsc_len),
    .dsc_sof   (dsc_sof),
    .dsc_eof   (dsc_eof),
    .dsc_ioc   (dsc_ioc),
    .dsc_eot   (dsc_eot),
    .tot_we    (tot_we),
    .tot_idx   (tot_idx),
    .wr_idx    (wr_idx),
    .nospc     (nospc),
    .nospc_cnt (nospc_cnt)
);

// File: tb/dseg_segmenter_test.sv
// Bench: small ring (8 slots), 16-byte cap; sweeps lengths, multi-entry
// messages and every occupancy/need pair; expectations computed here.
module dseg_segmenter_test;
    localparam int IDX_W  = 3;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 8;
    localparam int MAX_W  = 4;
    localparam int NEED_W = 4;
    localparam int REJ_W  = 3;
    localparam int CAP    = 16;
    localparam int SLOTS  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  cons_idx = '0;
    logic              hdr_valid = 1'b0;
    logic [NEED_W-1:0] hdr_need = '0;
    logic              hdr_ready;
    logic              ent_valid = 1'b0;
    logic [ADDR_W-1:0] ent_addr = '0;
    logic [LEN_W-1:0]  ent_len = '0;
    logic              ent_last = 1'b0;
    logic              ent_ready;
    logic              dsc_we;
    logic [IDX_W-1:0]  dsc_idx;
    logic [ADDR_W-1:0] dsc_addr;
    logic [MAX_W:0]    dsc_len;
    logic              dsc_sof, dsc_eof, dsc_ioc, dsc_eot;
    logic              tot_we;
    logic [IDX_W-1:0]  tot_idx;
    logic [IDX_W:0]    tot_cnt;
    logic [IDX_W-1:0]  wr_idx;
    logic              nospc;
    logic [REJ_W-1:0]  nospc_cnt;

    always #2 clk = ~clk;

    dseg_segmenter #(
        .IDX_W (IDX_W), .ADDR_W (ADDR_W), .LEN_W (LEN_W),
        .MAX_W (MAX_W), .NEED_W (NEED_W), .REJ_W (REJ_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cons_idx (cons_idx),
        .hdr_valid (hdr_valid), .hdr_need (hdr_need), .hdr_ready (hdr_ready),
        .ent_valid (ent_valid), .ent_addr (ent_addr), .ent_len (ent_len),
        .ent_last (ent_last), .ent_ready (ent_ready),
        .dsc_we (dsc_we), .dsc_idx (dsc_idx), .dsc_addr (dsc_addr),
        .dsc_len (dsc_len), .dsc_sof (dsc_sof), .dsc_eof (dsc_eof),
        .dsc_ioc (dsc_ioc), .dsc_eot (dsc_eot),
        .tot_we (tot_we), .tot_idx (tot_idx), .tot_cnt (tot_cnt),
        .wr_idx (wr_idx), .nospc (nospc), .nospc_cnt (nospc_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Expected descriptor list for the current message.
    int e_idx [0:63];
    int e_addr[0:63];
    int e_len [0:63];
    int e_sof [0:63];
    int e_eof [0:63];
    int e_eot [0:63];
    int e_wp = 0;
    int e_rp = 0;
    int exp_tidx = 0;
    int exp_tcnt = 0;
    int tot_seen = 0;

    // Bench model state.
    int m_wr  = 0;
    int m_rej = 0;

    // Entries of the next message.
    int ea[0:7];
    int el[0:7];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ndesc(input int len);
        if (len == 0) return 1;
        return (len + CAP - 1) / CAP;
    endfunction

    // Compare every descriptor and total strobe against the expected list.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dsc_we) begin
                if (e_rp >= e_wp) begin
                    check(1'b0, "R6", "unexpected descriptor at index", int'(dsc_idx), -1);
                end else begin
                    check(int'(dsc_idx) == e_idx[e_rp], "R5", "descriptor index", int'(dsc_idx), e_idx[e_rp]);
                    check(int'(dsc_addr) == e_addr[e_rp], "R1", "piece address", int'(dsc_addr), e_addr[e_rp]);
                    check(int'(dsc_len) == e_len[e_rp], "R1", "piece length", int'(dsc_len), e_len[e_rp]);
                    check(int'(dsc_sof) == e_sof[e_rp], "R2", "first flag", int'(dsc_sof), e_sof[e_rp]);
                    check(int'(dsc_eof) == e_eof[e_rp], "R3", "end flag", int'(dsc_eof), e_eof[e_rp]);
                    check(int'(dsc_ioc) == e_eof[e_rp], "R3", "interrupt flag", int'(dsc_ioc), e_eof[e_rp]);
                    check(int'(dsc_eot) == e_eot[e_rp], "R4", "wrap flag", int'(dsc_eot), e_eot[e_rp]);
                    e_rp++;
                end
            end
            if (tot_we) begin
                tot_seen++;
                check(int'(tot_idx) == exp_tidx, "R7", "total start index", int'(tot_idx), exp_tidx);
                check(int'(tot_cnt) == exp_tcnt, "R7", "total count", int'(tot_cnt), exp_tcnt);
            end
        end
    end

    // Offer one message of n entries (taken from ea/el) with the given need.
    task automatic send_msg(input int n, input int need);
        int occ, start, rem, a, chunk;
        bit ok, fin, first;
        occ   = (m_wr - int'(cons_idx)) & (SLOTS - 1);
        ok    = (need <= (SLOTS - 1 - occ));
        start = m_wr & (SLOTS - 1);
        e_wp = 0; e_rp = 0; tot_seen = 0;
        if (ok) begin
            first = 1'b1;
            for (int i = 0; i < n; i++) begin
                rem = el[i]; a = ea[i];
                do begin
                    fin   = (rem <= CAP);
                    chunk = fin ? rem : CAP;
                    e_idx[e_wp]  = m_wr & (SLOTS - 1);
                    e_addr[e_wp] = a & 16'hFFFF;
                    e_len[e_wp]  = chunk;
                    e_sof[e_wp]  = first ? 1 : 0;
                    e_eof[e_wp]  = (fin && (i == n - 1)) ? 1 : 0;
                    e_eot[e_wp]  = ((m_wr & (SLOTS - 1)) == SLOTS - 1) ? 1 : 0;
                    e_wp++; m_wr++; first = 1'b0;
                    a   = a + CAP;
                    rem = rem - chunk;
                end while (!fin);
            end
            exp_tidx = start;
            exp_tcnt = e_wp;
        end
        @(negedge clk);
        check(hdr_ready == 1'b1, "R10", "header ready while idle", int'(hdr_ready), 1);
        hdr_valid = 1'b1;
        hdr_need  = NEED_W'(need);
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        check(int'(nospc) == (ok ? 0 : 1), "R6", "admission decision (refusal pulse)", int'(nospc), ok ? 0 : 1);
        if (!ok) begin
            m_rej = (m_rej < 7) ? m_rej + 1 : 7;
            check(int'(nospc_cnt) == m_rej, "R8", "refusal counter", int'(nospc_cnt), m_rej);
            check(hdr_ready == 1'b1, "R10", "header ready after refusal", int'(hdr_ready), 1);
            @(negedge clk);
            check(nospc == 1'b0, "R8", "refusal pulse width", int'(nospc), 0);
            check(int'(wr_idx) == (m_wr & (SLOTS - 1)), "R6", "index after refusal", int'(wr_idx), m_wr & (SLOTS - 1));
        end else begin
            check(hdr_ready == 1'b0, "R10", "header ready while open", int'(hdr_ready), 0);
            for (int i = 0; i < n; i++) begin
                ent_valid = 1'b1;
                ent_addr  = ADDR_W'(ea[i]);
                ent_len   = LEN_W'(el[i]);
                ent_last  = (i == n - 1);
                while (!ent_ready) @(negedge clk);
                @(posedge clk);
                @(negedge clk);
                ent_valid = 1'b0;
                check(ent_ready == 1'b0, "R10", "entry ready while cutting", int'(ent_ready), 0);
            end
            while (!hdr_ready) @(negedge clk);
            @(negedge clk);
            check(e_rp == e_wp, "R1", "descriptors written", e_rp, e_wp);
            check(tot_seen == 1, "R7", "total strobes", tot_seen, 1);
            check(int'(wr_idx) == (m_wr & (SLOTS - 1)), "R5", "write index", int'(wr_idx), m_wr & (SLOTS - 1));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    int lens[0:12] = '{0, 1, 15, 16, 17, 31, 32, 33, 47, 48, 64, 100, 112};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(dsc_we == 1'b0 && tot_we == 1'b0 && nospc == 1'b0, "R9", "strobes in reset",
              int'({dsc_we, tot_we, nospc}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(wr_idx) == 0, "R9", "write index after reset", int'(wr_idx), 0);
        check(int'(nospc_cnt) == 0, "R9", "refusal counter after reset", int'(nospc_cnt), 0);
        check(hdr_ready == 1'b1, "R9", "header ready after reset", int'(hdr_ready), 1);

        // R1/R4/R5: single-entry length sweep around the cap, ring kept empty.
        for (int k = 0; k < 13; k++) begin
            cons_idx = IDX_W'(m_wr);
            ea[0] = 16'h1000 + k * 37;
            el[0] = lens[k];
            send_msg(1, ndesc(lens[k]));
        end

        // R2/R3/R7: multi-entry messages.
        for (int k = 0; k < 6; k++) begin
            cons_idx = IDX_W'(m_wr);
            ea[0] = 16'h2000 + k; el[0] = 5 + k;
            ea[1] = 16'h3000;     el[1] = 16 * (k % 3) + k;
            ea[2] = 16'h4000 + k; el[2] = 16;
            send_msg(3, ndesc(el[0]) + ndesc(el[1]) + ndesc(el[2]));
        end

        // R6/R8: every occupancy against every need up to one past the ring.
        for (int occ = 0; occ < SLOTS; occ++) begin
            for (int need = 1; need <= SLOTS; need++) begin
                cons_idx = IDX_W'((m_wr - occ) & (SLOTS - 1));
                ea[0] = 16'h5000 + occ * 64 + need;
                el[0] = need * CAP;
                send_msg(1, need);
            end
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule